// File: doc/BRIEF.md
# Differential Decimating Noise Averager

This block takes two ADC sample streams that are captured on the same clock and subtracts one from the other, so that noise both channels share drops out of the result. A free-running 2-bit phase counter splits the stream into slots of four samples. Only the sample in the chosen slot is used, which gives one difference value per carrier period. The slot select is the same value the point tracker uses, so both blocks work on the same phase of the carrier.

The decimated differences go through an accumulate-and-dump stage. After N = 2^k terms it writes the floor average into the next word of a capture buffer and clears itself. A start pulse arms a capture. When the buffer is full the block raises a done flag and stops writing. The buffer can then be read through a port with one cycle of latency. The buffer depth is a parameter of 2^BUF_AW words. A full-length capture of 16384 words of 32 bits uses BUF_AW = 14. The default is smaller so that elaboration stays light.

Top module: `diff_noise_averager`

## Requirements
- R1: After reset, `done` is 0, `sampleCount` is 0 and `rdData` is 0.
- R2: The difference is chanA minus chanB, with both inputs read as 14-bit two's complement. It is formed at 15 bits, so the extreme pair 8191 and -8192 gives +16383 with no wrap.
- R3: A 2-bit phase counter is 0 in the first cycle after reset and adds 1 on every clock. A pair of samples is used only in a cycle where this phase equals `slotSel`, and only while a capture is active. No other cycle changes the result.
- R4: The averaging length is N = 2^avgLog, with `avgLog` latched by the start pulse. Any value above 10 is treated as 10. Each stored word is the sum of N used differences shifted arithmetically right by log2(N), which is the floor of the mean, sign-extended to 32 bits.
- R5: A start pulse clears the write pointer, the accumulator, the term count and `done`. A start during a capture throws away the partial sum, and the sample pair in the start cycle is not used.
- R6: Words are written to consecutive addresses starting at 0. `sampleCount` gives the number of words written so far and never moves by more than one per clock.
- R7: `done` rises with the final write, when `sampleCount` equals the depth. After that it holds and no word is written until the next start.
- R8: `rdData` shows the word at the `rdAddr` that was present at the previous clock edge.
- R9: If both channels carry identical samples, every stored word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Active-low synchronous reset |
| chanA | input | 14 | Channel A sample, two's complement |
| chanB | input | 14 | Channel B sample, two's complement |
| slotSel | input | 2 | Phase slot that is kept from each group of four |
| avgLog | input | 4 | log2 of the averaging length, latched at start |
| start | input | 1 | One-cycle pulse that begins a capture |
| rdAddr | input | BUF_AW | Capture buffer read address |
| rdData | output | 32 | Registered read word |
| done | output | 1 | Capture buffer full |
| sampleCount | output | BUF_AW+1 | Words written in the current capture |

## Verification
The function is exercised with four patterns:
- **Independent random samples on both channels, with a per-cycle value.** A wrong slot or a wrong subtraction order changes the stored words.
- **Identical samples on both channels.** The result must be zero, which shows that common-mode content cancels.
- **Small signed random values with N = 8.** This separates a floor shift from a truncating divide.
- **The extreme pair held constant with an oversized `avgLog`.** This proves both the 15-bit difference width and the clamp to 1024 terms.

A restart in the middle of a capture and continued stimulus after `done` show that partial sums are discarded and that a full buffer is left alone.

// File: rtl/dna_pkg.sv
package dna_pkg;
  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic clear;   // start: zero accumulator
    logic accum;   // add current difference
    logic dump;    // last term: emit average, write buffer, zero accumulator
  } dnaStrobe_t;
endpackage

// File: rtl/dna_ctrl.sv
module dna_ctrl
  import dna_pkg::*;
#(
  parameter int BUF_AW  = 12,
  parameter int MAX_LOG = 10,
  parameter int SLOT_W  = 2,
  parameter int LOG_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [SLOT_W-1:0]   slotSel,
  input  logic [LOG_W-1:0]    avgLog,
  output dnaStrobe_t          strobes,
  output logic [LOG_W-1:0]    shift,
  output logic [BUF_AW-1:0]   wrAddr,
  output logic [BUF_AW:0]     sampleCount,
  output logic                done
);
  localparam int DEPTH = 1 << BUF_AW;

  logic [SLOT_W-1:0]  phase;
  logic               active;
  logic [MAX_LOG-1:0] termCnt;
  logic [BUF_AW:0]    wrPtr;
  logic [LOG_W-1:0]   shiftQ;
  logic [LOG_W-1:0]   logClamped;
  logic [MAX_LOG:0]   termLimit;
  logic               take;
  logic               lastTerm;
  logic               lastWord;

  assign logClamped = (avgLog > LOG_W'(MAX_LOG)) ? LOG_W'(MAX_LOG) : avgLog;
  assign termLimit  = ((MAX_LOG+1)'(1) << shiftQ) - (MAX_LOG+1)'(1);
  assign take       = active && !start && (phase == slotSel);
  assign lastTerm   = (termCnt == termLimit[MAX_LOG-1:0]);
  assign lastWord   = (wrPtr == (BUF_AW+1)'(DEPTH - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= '0;
      active  <= 1'b0;
      termCnt <= '0;
      wrPtr   <= '0;
      shiftQ  <= '0;
      done    <= 1'b0;
    end else begin
      phase <= phase + 1'b1;
      if (start) begin
        active  <= 1'b1;
        termCnt <= '0;
        wrPtr   <= '0;
        done    <= 1'b0;
        shiftQ  <= logClamped;
      end else if (take) begin
        if (lastTerm) begin
          termCnt <= '0;
          wrPtr   <= wrPtr + 1'b1;
          if (lastWord) begin
            active <= 1'b0;
            done   <= 1'b1;
          end
        end else begin
          termCnt <= termCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    strobes.clear = start;
    strobes.accum = take && !lastTerm;
    strobes.dump  = take && lastTerm;
  end

  assign shift       = shiftQ;
  assign wrAddr      = wrPtr[BUF_AW-1:0];
  assign sampleCount = wrPtr;
endmodule

// File: rtl/dna_datapath.sv
module dna_datapath
  import dna_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int MAX_LOG  = 10,
  parameter int LOG_W    = 4,
  parameter int WORD_W   = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] chanA,
  input  logic [SAMPLE_W-1:0] chanB,
  input  dnaStrobe_t          strobes,
  input  logic [LOG_W-1:0]    shift,
  output logic [WORD_W-1:0]   wrData
);
  localparam int DIFF_W = SAMPLE_W + 1;
  localparam int ACC_W  = DIFF_W + MAX_LOG;

  logic signed [DIFF_W-1:0] extA, extB, diff;
  logic signed [ACC_W-1:0]  diffWide, acc, sum, avg;

  assign extA     = {chanA[SAMPLE_W-1], chanA};
  assign extB     = {chanB[SAMPLE_W-1], chanB};
  assign diff     = extA - extB;
  assign diffWide = {{MAX_LOG{diff[DIFF_W-1]}}, diff};
  assign sum      = acc + diffWide;
  assign avg      = sum >>> shift;

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clear || strobes.dump) acc <= '0;
    else if (strobes.accum)                   acc <= sum;
  end

  generate
    if (WORD_W >= ACC_W) begin : g_signExtend
      assign wrData = {{(WORD_W-ACC_W){avg[ACC_W-1]}}, avg};
    end else begin : g_truncate
      assign wrData = avg[WORD_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/dna_capture_ram.sv
module dna_capture_ram #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          we,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/diff_noise_averager.sv
module diff_noise_averager
  import dna_pkg::*;
#(
  parameter int SAMPLE_W = 14,
  parameter int BUF_AW   = 12,
  parameter int WORD_W   = 32,
  parameter int MAX_LOG  = 10,
  parameter int SLOT_W   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [SAMPLE_W-1:0] chanA,
  input  logic [SAMPLE_W-1:0] chanB,
  input  logic [SLOT_W-1:0]   slotSel,
  input  logic [3:0]          avgLog,
  input  logic                start,
  input  logic [BUF_AW-1:0]   rdAddr,
  output logic [WORD_W-1:0]   rdData,
  output logic                done,
  output logic [BUF_AW:0]     sampleCount
);
  localparam int LOG_W = 4;

  dnaStrobe_t          strobes;
  logic [LOG_W-1:0]    shift;
  logic [BUF_AW-1:0]   wrAddr;
  logic [WORD_W-1:0]   wrData;
  logic                wrEn;

  assign wrEn = strobes.dump;

  dna_ctrl #(.BUF_AW(BUF_AW), .MAX_LOG(MAX_LOG), .SLOT_W(SLOT_W), .LOG_W(LOG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .slotSel(slotSel), .avgLog(avgLog),
    .strobes(strobes), .shift(shift), .wrAddr(wrAddr),
    .sampleCount(sampleCount), .done(done)
  );

  dna_datapath #(.SAMPLE_W(SAMPLE_W), .MAX_LOG(MAX_LOG), .LOG_W(LOG_W), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB),
    .strobes(strobes), .shift(shift), .wrData(wrData)
  );

  dna_capture_ram #(.AW(BUF_AW), .DW(WORD_W)) u_ram (
    .clk(clk), .rstN(rstN), .we(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/dna_checker.sv
module dna_checker #(
  parameter int BUF_AW = 12
) (
  input logic            clk,
  input logic            rstN,
  input logic            start,
  input logic            done,
  input logic [BUF_AW:0] sampleCount,
  input logic            wrEn
);
  localparam int DEPTH = 1 << BUF_AW;

  // R5
  start_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (sampleCount == '0 && !done));

  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (sampleCount == $past(sampleCount) || sampleCount == $past(sampleCount) + 1'b1));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> (done && $stable(sampleCount)));

  // R7
  done_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (sampleCount == (BUF_AW+1)'(DEPTH)));

  // R3
  write_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !wrEn);

  // R7
  no_write_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wrEn);
endmodule

bind diff_noise_averager dna_checker #(.BUF_AW(BUF_AW)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .sampleCount(sampleCount), .wrEn(wrEn)
);

// File: tb/diff_noise_averager_test.sv
module diff_noise_averager_test;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic              clk = 0;
  logic              rstN = 0;
  logic [13:0]       chanA = '0, chanB = '0;
  logic [1:0]        slotSel = '0;
  logic [3:0]        avgLog = '0;
  logic              start = 0;
  logic [AW-1:0]     rdAddr = '0;
  logic [31:0]       rdData;
  logic              done;
  logic [AW:0]       sampleCount;

  int checks = 0, failures = 0, cycles = 0;

  diff_noise_averager #(.BUF_AW(AW)) uut (
    .clk(clk), .rstN(rstN), .chanA(chanA), .chanB(chanB), .slotSel(slotSel),
    .avgLog(avgLog), .start(start), .rdAddr(rdAddr), .rdData(rdData),
    .done(done), .sampleCount(sampleCount)
  );

  always #10 clk = ~clk;

  // behavioural reference
  int     mPhase, mCnt, mWr, mLog;
  bit     mActive, mDone;
  longint mAcc, d;
  int     mMem [DEPTH];

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mActive = 0; mDone = 0; mCnt = 0; mWr = 0; mAcc = 0; mLog = 0;
    end else begin
      if (start) begin
        mActive = 1; mWr = 0; mAcc = 0; mCnt = 0; mDone = 0;
        mLog = (avgLog > 10) ? 10 : int'(avgLog);
      end else if (mActive && mPhase == int'(slotSel)) begin
        d = longint'($signed(chanA)) - longint'($signed(chanB));
        if (mCnt == (1 << mLog) - 1) begin
          mMem[mWr] = int'((mAcc + d) >>> mLog);
          mWr++; mAcc = 0; mCnt = 0;
          if (mWr == DEPTH) begin mDone = 1; mActive = 0; end
        end else begin
          mAcc += d; mCnt++;
        end
      end
      mPhase = (mPhase + 1) % 4;
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // per-cycle comparison, R6/R7
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      check(done == mDone, "R7 done", done, mDone);
      check(int'(sampleCount) == mWr, "R6 sampleCount", sampleCount, mWr);
    end
    if (cycles > 190000) begin
      check(0, "watchdog", cycles, 190000);
      finishRun();
    end
  end

  task automatic drive(input int mode);
    int v;
    case (mode)
      0: begin chanA = 14'($urandom); chanB = 14'($urandom); end
      1: begin v = $urandom; chanA = 14'(v); chanB = 14'(v); end
      2: begin chanA = 14'sd8191; chanB = -14'sd8192; end
      default: begin
        chanA = 14'($signed($urandom_range(6)) - 3);
        chanB = 14'($signed($urandom_range(6)) - 3);
      end
    endcase
  endtask

  task automatic pulseStart(input int slot, input int lg);
    @(negedge clk);
    slotSel = 2'(slot); avgLog = 4'(lg); start = 1;
    drive(0);
    @(negedge clk);
    start = 0;
  endtask

  task automatic runToDone(input int mode);
    int n = 0;
    while (!mDone && n < 150000) begin
      drive(mode);
      @(negedge clk);
      n++;
    end
    check(mDone, "R7 capture completes", mDone, 1);
  endtask

  task automatic readBack(input string req);
    for (int i = 0; i < DEPTH; i++) begin
      rdAddr = AW'(i);
      @(negedge clk);
      // R8: word visible one edge after address
      check($signed(rdData) == mMem[i], req, $signed(rdData), mMem[i]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(done == 0, "R1 done", done, 0);
    check(sampleCount == 0, "R1 sampleCount", sampleCount, 0);
    check(rdData == 0, "R1 rdData", rdData, 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R2 R3: independent random, slot 1, N=1
    pulseStart(1, 0);
    runToDone(0);
    readBack("R3 random slot1 N1");

    // R9: common-mode cancels
    pulseStart(3, 2);
    runToDone(1);
    readBack("R9 common mode");
    for (int i = 0; i < DEPTH; i++)
      check(mMem[i] == 0, "R9 model zero", mMem[i], 0);

    // R4: floor average, N=8, slot 2
    pulseStart(2, 3);
    runToDone(3);
    readBack("R4 floor avg N8");

    // R5: restart mid-capture with different length
    pulseStart(0, 1);
    repeat (37) begin drive(0); @(negedge clk); end
    check(sampleCount != 0, "R5 partial progress", sampleCount, 1);
    pulseStart(1, 2);
    check(sampleCount == 0, "R5 pointer cleared", sampleCount, 0);
    runToDone(0);
    readBack("R5 restart");

    // R7: no writes after done
    repeat (60) begin drive(0); @(negedge clk); end
    check(done == 1, "R7 done holds", done, 1);
    readBack("R7 buffer untouched");

    // R2 R4: extremes, avgLog 15 clamps to 10
    pulseStart(0, 15);
    runToDone(2);
    readBack("R2 extreme diff");
    check(mMem[0] == 16383, "R2 model extreme", mMem[0], 16383);

    finishRun();
  end
endmodule